// File: doc/BRIEF.md
# Bus-Mapped Serial Port Register Front End

This block is the register face of a simple serial port, sitting on an APB-style peripheral bus. Bytes arriving from the receive side come in on a valid/ready byte stream and collect in an on-chip receive store. Software drains them by reading the data register. Writing the data register sends the low byte of the write data out on a transmit byte stream. Nothing is kept on the transmit side.

Alongside the data register there is a read-only status word that carries a data-ready flag, and a fully writable control word. A single interrupt output fires once for each received byte while the receive-interrupt enable is set. The receive store grows from its fill count and drains through a separate read index. It returns to empty only when every stored byte has been read, so space is not recovered by partial reads. Transfers complete without wait states. Only the low eight address bits take part in decoding.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, status and control read as zero, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: A write access at offset 0x00 or 0x03 raises `tx_valid` for exactly one cycle, with `tx_data` equal to `pwdata[7:0]`.
- R3: A byte offered while `rx_ready` is high is stored. Reads at offset 0x00 or 0x03 return the stored bytes oldest first, in `prdata[7:0]`, with the upper bits zero.
- R4: A data-register read with no unread byte returns zero.
- R5: Status (offset 0x04) bit 0 is data-ready. It is set when a byte is accepted and cleared by a data read that leaves no unread byte. Status bits 31..1 always read zero.
- R6: The store holds 1024 bytes, and `rx_ready` is low when 1024 are held. The fill count returns to zero only when all held bytes have been read, so `rx_ready` stays low after a partial drain.
- R7: Control (offset 0x08) stores all 32 written bits and reads them back.
- R8: When control bit 2 is set, each accepted byte raises `irq` for one cycle, in the cycle after acceptance. When control bit 2 is clear, `irq` stays low.
- R9: Offsets 0x0C, 0x10 and any other undecoded offset read zero. Writes to them change no state and emit no byte.
- R10: A data read and an accepted byte in the same cycle both take effect. The read returns the older byte, and the store is not emptied in that cycle.
- R11: Address bits above bit 7 are ignored, so 0x108 reaches control and 0x100 reaches data.
- R12: Writes to status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 32 | Byte address (low 8 bits decoded) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive store has room |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Receive interrupt pulse |

## Verification
A bus read of the data register and the acceptance of a new receive byte can land in the same clock cycle. This matters most when the read takes the last unread byte, because the store would then want to empty itself. The bench provokes this by raising `rx_valid` in the access phase of a data read, once while a single byte is held and once while the store is empty. It then judges the result against a queue model: the read must return the older byte (or zero), and the new byte must be returned by the next read with data-ready still set.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam logic [7:0] OFS_DATA      = 8'h00;
  localparam logic [7:0] OFS_DATA_BYTE = 8'h03;
  localparam logic [7:0] OFS_STAT      = 8'h04;
  localparam logic [7:0] OFS_CTRL      = 8'h08;

  localparam int RDY_BIT  = 0;
  localparam int RXIE_BIT = 2;

endpackage

// File: rtl/sp_addr_decode.sv
module sp_addr_decode
  import serial_port_pkg::*;
#(
  parameter int DEC_W = 8
) (
  input  logic [DEC_W-1:0] addr,
  output reg_sel_e         sel
);

  always_comb begin
    unique case (addr)
      DEC_W'(OFS_DATA),
      DEC_W'(OFS_DATA_BYTE): sel = SEL_DATA;
      DEC_W'(OFS_STAT):      sel = SEL_STAT;
      DEC_W'(OFS_CTRL):      sel = SEL_CTRL;
      default:               sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sp_rx_store.sv
module sp_rx_store #(
  parameter int DEPTH  = 1024,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic              ready,
  output logic              accept,
  output logic              avail,
  output logic              last,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  rd_idx
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  idx_inc;
  logic              do_pop;
  logic [IDX_W-1:0]  wr_addr;
  logic [IDX_W-1:0]  rd_addr;

  assign ready   = (fill < CNT_W'(DEPTH));
  assign accept  = push && ready;
  assign avail   = (rd_idx < fill);
  assign idx_inc = rd_idx + CNT_W'(1);
  assign last    = (idx_inc >= fill);
  assign do_pop  = pop && avail;
  assign wr_addr = fill[IDX_W-1:0];
  assign rd_addr = rd_idx[IDX_W-1:0];

  // storage array: plain write port, no reset
  always_ff @(posedge clk) begin
    if (accept) mem[wr_addr] <= push_data;
  end

  // registered head with write-first bypass
  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
    end else if (accept && (wr_addr == rd_addr)) begin
      head <= push_data;
    end else begin
      head <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill   <= '0;
      rd_idx <= '0;
    end else if (do_pop && !accept && (idx_inc == fill)) begin
      fill   <= '0;
      rd_idx <= '0;
    end else begin
      fill   <= fill + CNT_W'(accept);
      rd_idx <= do_pop ? idx_inc : rd_idx;
    end
  end

endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int PADDR_W = 32,
  parameter int PDATA_W = 32,
  parameter int DEC_W   = 8,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [PDATA_W-1:0] pwdata,
  output logic [PDATA_W-1:0] prdata,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_data,
  output logic               rx_ready,
  output logic               tx_valid,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               irq
);

  reg_sel_e           sel;
  logic               acc_rd;
  logic               acc_wr;
  logic               pop;
  logic               accept;
  logic               avail;
  logic               last;
  logic [BYTE_W-1:0]  head;
  logic [CNT_W-1:0]   fill;
  logic [CNT_W-1:0]   rd_idx;
  logic [PDATA_W-1:0] ctrl_q;
  logic               rdy_q;
  logic               unused_hi;

  assign unused_hi = ^paddr[PADDR_W-1:DEC_W];

  sp_addr_decode #(.DEC_W(DEC_W)) u_dec (
    .addr (paddr[DEC_W-1:0]),
    .sel  (sel)
  );

  assign acc_rd = psel && penable && !pwrite;
  assign acc_wr = psel && penable && pwrite;
  assign pop    = acc_rd && (sel == SEL_DATA);

  sp_rx_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (pop),
    .ready     (rx_ready),
    .accept    (accept),
    .avail     (avail),
    .last      (last),
    .head      (head),
    .fill      (fill),
    .rd_idx    (rd_idx)
  );

  // control word
  always_ff @(posedge clk) begin
    if (rst)                              ctrl_q <= '0;
    else if (acc_wr && sel == SEL_CTRL)   ctrl_q <= pwdata;
  end

  // data-ready flag: arrival wins over a draining read
  always_ff @(posedge clk) begin
    if (rst)              rdy_q <= 1'b0;
    else if (accept)      rdy_q <= 1'b1;
    else if (pop && last) rdy_q <= 1'b0;
  end

  // transmit strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= acc_wr && (sel == SEL_DATA);
      if (acc_wr && sel == SEL_DATA) tx_data <= pwdata[BYTE_W-1:0];
    end
  end

  // receive interrupt pulse
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= accept && ctrl_q[RXIE_BIT];
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (sel)
        SEL_DATA: if (avail) prdata[BYTE_W-1:0] = head;
        SEL_STAT: prdata[RDY_BIT] = rdy_q;
        SEL_CTRL: prdata = ctrl_q;
        default:  prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/serial_port_regs_chk.sv
module serial_port_regs_chk #(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [7:0]       addr_lo,
  input logic [31:0]      prdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             irq,
  input logic [CNT_W-1:0] fill,
  input logic [CNT_W-1:0] rd_idx,
  input logic             rdy_q,
  input logic             rie
);

  logic fire;
  logic data_rd;
  assign fire    = rx_valid && rx_ready;
  assign data_rd = psel && penable && !pwrite && (addr_lo == 8'h00 || addr_lo == 8'h03);

  a_r2_tx_from_write: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(psel && penable && pwrite));

  a_r3_fill_grows: assert property (@(posedge clk) disable iff (rst)
    fire |=> fill == $past(fill) + CNT_W'(1));

  a_r3_index_bound: assert property (@(posedge clk) disable iff (rst)
    rd_idx <= fill);

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (data_rd && fill == '0) |-> prdata == 32'h0);

  a_r5_flag_tracks_fill: assert property (@(posedge clk) disable iff (rst)
    rdy_q == (rd_idx < fill));

  a_r6_fill_limit: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(fire && rie));

  a_r10_no_flush_on_arrival: assert property (@(posedge clk) disable iff (rst)
    fire |=> fill != '0);

endmodule

bind serial_port_regs serial_port_regs_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .addr_lo  (paddr[7:0]),
  .prdata   (prdata),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .irq      (irq),
  .fill     (fill),
  .rd_idx   (rd_idx),
  .rdy_q    (rdy_q),
  .rie      (ctrl_q[2])
);

// File: tb/serial_port_regs_test.sv
module serial_port_regs_test;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  serial_port_regs uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int checks = 0, errors = 0;
  int exp_irq = 0, irq_seen = 0;
  int mfill = 0, midx = 0;
  logic [31:0] mctrl = '0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: transmit bytes against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (txq.size() == 0) chk("R9 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 tx byte", {24'h0, tx_data}, {24'h0, txq.pop_front()});
    end
    if (!rst && irq) irq_seen++;
  end

  function automatic bit is_data(input logic [31:0] a);
    return (a[7:0] == 8'h00) || (a[7:0] == 8'h03);
  endfunction

  function automatic logic [7:0] model_read(input bit arrival);
    logic [7:0] v;
    if (midx < mfill) begin
      v = rxq.pop_front();
      midx++;
      if (midx == mfill && !arrival) begin mfill = 0; midx = 0; end
    end else v = 8'h00;
    return v;
  endfunction

  function automatic void model_push(input logic [7:0] b);
    rxq.push_back(b);
    mfill++;
    if (mctrl[2]) exp_irq++;
  endfunction

  task automatic xfer(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                      input bit with_rx, input logic [7:0] rb, output logic [31:0] rd);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1;
    if (with_rx) begin rx_valid = 1; rx_data = rb; end
    #1 rd = prdata;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; rx_valid = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    if (is_data(a)) txq.push_back(d[7:0]);
    if (a[7:0] == 8'h08) mctrl = d;
    xfer(a, 1'b1, d, 1'b0, 8'h00, dummy);
  endtask

  task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    xfer(a, 1'b0, '0, 1'b0, 8'h00, v);
    chk(tag, v, exp);
  endtask

  task automatic rd_data(input logic [31:0] a, input string tag);
    logic [31:0] v;
    logic [7:0]  e;
    e = model_read(1'b0);
    xfer(a, 1'b0, '0, 1'b0, 8'h00, v);
    chk(tag, v, {24'h0, e});
  endtask

  task automatic rd_data_rx(input logic [31:0] a, input logic [7:0] b, input string tag);
    logic [31:0] v;
    logic [7:0]  e;
    e = model_read(1'b1);
    model_push(b);
    xfer(a, 1'b0, '0, 1'b1, b, v);
    chk(tag, v, {24'h0, e});
  endtask

  task automatic rx_burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R6 rx_ready vs fill", {31'h0, rx_ready}, {31'h0, (mfill < DEPTH)});
      rx_valid = 1; rx_data = base + 8'(i);
      if (mfill < DEPTH) model_push(base + 8'(i));
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic irq_chk(input string tag);
    @(negedge clk); @(negedge clk);
    chk(tag, irq_seen, exp_irq);
  endtask

  task automatic stat_chk(input string tag);
    rd_chk(32'h04, {31'h0, (rxq.size() != 0)}, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd_chk(32'h04, 32'h0, "R1 status");
    rd_chk(32'h08, 32'h0, "R1 control");

    // R7 full control readback, enables interrupt (bit 2)
    wr(32'h08, 32'hDEAD_BEE4);
    rd_chk(32'h08, 32'hDEAD_BEE4, "R7 control readback");

    // R3 R5 R8 basic receive
    rx_burst(3, 8'h11);
    irq_chk("R8 one pulse per byte");
    stat_chk("R5 ready set");
    rd_data(32'h00, "R3 first byte");
    rd_data(32'h03, "R3 byte offset alias");
    stat_chk("R5 still ready");
    rd_data(32'h00, "R3 last byte");
    stat_chk("R5 ready cleared");
    rd_data(32'h00, "R4 empty read");
    rd_data(32'h03, "R4 empty read byte offset");

    // R8 disabled
    wr(32'h08, 32'h0000_0000);
    rx_burst(1, 8'h5C);
    irq_chk("R8 no irq when disabled");
    rd_data(32'h00, "R3 read after disable");

    // R2 transmit
    wr(32'h00, 32'h1234_01C3);
    wr(32'h03, 32'h0000_005A);
    repeat (2) @(negedge clk);
    chk("R2 tx queue drained", txq.size(), 0);

    // R9 R12 ignored offsets
    wr(32'h08, 32'h0000_0004);
    wr(32'h0C, 32'hFFFF_FFFF);
    wr(32'h10, 32'hFFFF_FFFF);
    wr(32'h20, 32'hFFFF_FFFF);
    wr(32'h04, 32'hFFFF_FFFF);
    rd_chk(32'h08, 32'h0000_0004, "R9 control untouched");
    stat_chk("R12 status untouched");
    rd_chk(32'h0C, 32'h0, "R9 scaler reads zero");
    rd_chk(32'h10, 32'h0, "R9 debug reads zero");
    rd_chk(32'h44, 32'h0, "R9 unknown reads zero");

    // R11 upper address bits ignored
    wr(32'h108, 32'h0000_0006);
    rd_chk(32'h208, 32'h0000_0006, "R11 control alias");
    rx_burst(1, 8'hA7);
    rd_data(32'h100, "R11 data alias");
    wr(32'h08, 32'h0000_0004);

    // R10 read and arrival in the same cycle
    rx_burst(1, 8'h77);
    rd_data_rx(32'h00, 8'h88, "R10 read during arrival");
    stat_chk("R10 ready kept");
    rd_data(32'h00, "R10 new byte kept");
    stat_chk("R10 ready cleared after drain");
    rd_data_rx(32'h00, 8'h99, "R10 empty read during arrival");
    stat_chk("R10 ready set by arrival");
    rd_data(32'h03, "R10 arrived byte");
    irq_chk("R8 irq count after mixed traffic");

    // R6 fill to capacity
    rx_burst(DEPTH + 1, 8'h00);
    chk("R6 full blocks", {31'h0, rx_ready}, 32'h0);
    rd_data(32'h00, "R6 read from full");
    rd_data(32'h00, "R6 read from full 2");
    @(negedge clk);
    chk("R6 no space after partial drain", {31'h0, rx_ready}, 32'h0);
    while (rxq.size() != 0) rd_data(32'h00, "R3 drain order");
    @(negedge clk);
    chk("R6 space after full drain", {31'h0, rx_ready}, 32'h1);
    stat_chk("R5 ready clear after drain");
    irq_chk("R8 irq count after fill");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule